// File: doc/BRIEF.md
# Swept Phase-Shift Bridge Gate Generator

This block drives the twelve gate lines of three full-bridge power stages through one macro-pulse at a time. It sweeps two quantities linearly across each pulse to counter the sag of a converter's output as its storage bank discharges. The first is the switching period. The second is the phase-modulation setting, which delays one leg of each bridge relative to the other.

Switching periods are given in clock cycles. Phase modulation is given in percent, where 100 means both legs switch together. The per-period step of each ramp is computed once at the trigger with fixed-point arithmetic. Each period and its leg delay are applied only at a period boundary, so no gate edge is ever cut short.

All settings pass through clamps before use. The period must lie inside a fixed window, and its sweep span is limited. Phase modulation never drops below 90 percent. Each leg's upper and lower switch are separated by a programmable dead time. Dropping the enable input blanks every gate at once and ends the pulse.

Top module: `swept_bridge_gate_gen`

## Requirements
- R1: While reset is asserted, and right after it, `active` is low and every gate line is low.
- R2: A rising edge on `trig` with `en` high and no pulse running starts a pulse.
  - All settings are captured at that edge.
  - `active` goes high the next cycle and stays high for exactly the sum of the N switching periods, where N is `n_periods` and 0 counts as 1. Then it falls.
  - Gates are low whenever `active` is low.
- R3: The period of switching period k (from 0) is Ps + s·floor(inc·k / 2^FW), where inc = floor(|Pe−Ps|·2^FW / (N−1)) (inc is 0 when N ≤ 1), and s is +1 when Pe ≥ Ps and −1 otherwise. Ps and Pe are the clamped start and end periods.
- R4: Both period settings are first clamped into [PER_MIN, PER_MAX]. The end period is then limited to within SPAN_MAX clock cycles of the start period.
- R5: The phase setting of period k follows the same ramp rule over the clamped start and end settings. That period's leg delay is floor(P·(100−M)/100) clock cycles, where P is the period and M the setting.
- R6: Phase settings below 90 are raised to 90, and settings above 100 are lowered to 100.
- R7: Gate bit 4b+0 is the upper switch of leg A of bridge b, bit 4b+1 its lower switch, bit 4b+2 the upper switch of leg B, and bit 4b+3 its lower switch. All three bridges carry the same pattern. Let c be the cycle count in the period, h = P/2 (rounded down), d the dead time, and c2 = (c − delay) mod P. Then:
  - A upper is on for d ≤ c < h, and A lower for c ≥ h+d.
  - B lower is on for d ≤ c2 < h, and B upper for c2 ≥ h+d.
- R8: The upper and lower switch of one leg are never on in the same cycle.
- R9: With `en` low, all gates are low in that same cycle. The running pulse ends at the next clock. Gates stay low until a later trigger arrives with `en` high. A trigger edge while `en` is low starts nothing.
- R10: A trigger edge during a pulse is ignored. Changing the settings during a pulse does not alter the running pulse.
- R11: The period and leg delay in force stay constant inside a switching period and change only at its boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Pulse trigger, rising edge starts a pulse |
| en | input | 1 | Enable; low acts as a fault shutdown |
| per_start | input | CW | Switching period at pulse start, in clocks |
| per_end | input | CW | Switching period at pulse end, in clocks |
| pm_start | input | 7 | Phase modulation at pulse start, percent |
| pm_end | input | 7 | Phase modulation at pulse end, percent |
| n_periods | input | KW | Switching periods per pulse |
| dead | input | DW | Dead time between a leg's switches, in clocks |
| gate | output | 4*NB | Gate lines, four per bridge |
| active | output | 1 | High while a pulse runs |

## Verification
Pulses are run over a grid of start periods covering the whole clamp window. The grid combines pulse lengths of one, two, three and six periods with several phase starts and dead times. Every gate line is compared in every cycle against a pattern computed arithmetically from the ramp formulas.

Named pulses add rising and falling sweeps, which separate the sign handling of both ramps. Settings outside the range, outside the span and below the phase floor show whether each clamp acts and in what order. A pulse that is re-triggered and fed new settings midway shows whether a running pulse can be disturbed. A pulse cut short by `en` shows the same-cycle blanking, and a trigger sent while disabled shows that it is refused.

// File: rtl/swept_bridge_gate_gen.sv
module swept_bridge_gate_gen #(
  parameter int NB       = 3,
  parameter int CW       = 16,
  parameter int KW       = 12,
  parameter int DW       = 8,
  parameter int FW       = 8,
  parameter int PER_MIN  = 4348,
  parameter int PER_MAX  = 5883,
  parameter int SPAN_MAX = 455,
  parameter int PM_FLOOR = 90
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            en,
  input  logic [CW-1:0]   per_start,
  input  logic [CW-1:0]   per_end,
  input  logic [6:0]      pm_start,
  input  logic [6:0]      pm_end,
  input  logic [KW-1:0]   n_periods,
  input  logic [DW-1:0]   dead,
  output logic [4*NB-1:0] gate,
  output logic            active
);
  localparam int AW = CW + FW;
  localparam int MW = 7 + FW;
  localparam int XW = CW + 1;
  localparam logic [CW-1:0] PMIN = CW'(PER_MIN);
  localparam logic [CW-1:0] PMAX = CW'(PER_MAX);
  localparam logic [XW-1:0] SPANX = XW'(SPAN_MAX);
  localparam logic [6:0]    PMF  = 7'(PM_FLOOR);

  function automatic logic [CW-1:0] clamp_per(input logic [CW-1:0] p);
    if (p < PMIN) return PMIN;
    if (p > PMAX) return PMAX;
    return p;
  endfunction

  function automatic logic [6:0] clamp_pm(input logic [6:0] m);
    if (m < PMF) return PMF;
    if (m > 7'd100) return 7'd100;
    return m;
  endfunction

  function automatic logic [CW-1:0] shift_of(input logic [CW-1:0] p, input logic [6:0] m);
    logic [CW+6:0] prod;
    prod = p * (7'd100 - m);
    return CW'(prod / (CW+7)'(100));
  endfunction

  // settings conditioning
  logic [CW-1:0] ps_c, pe_r, pe_c, per_mag;
  logic [6:0]    ms_c, me_c, pm_mag;
  logic          per_up, pm_up;
  logic [KW-1:0] nm1, klast_n;
  logic [AW-1:0] per_inc_n;
  logic [MW-1:0] pm_inc_n;

  assign ps_c = clamp_per(per_start);
  assign pe_r = clamp_per(per_end);
  always_comb begin
    if ({1'b0, pe_r} > {1'b0, ps_c} + SPANX)      pe_c = ps_c + CW'(SPAN_MAX);
    else if ({1'b0, pe_r} + SPANX < {1'b0, ps_c}) pe_c = ps_c - CW'(SPAN_MAX);
    else                                          pe_c = pe_r;
  end
  assign per_up  = pe_c >= ps_c;
  assign per_mag = per_up ? pe_c - ps_c : ps_c - pe_c;
  assign ms_c    = clamp_pm(pm_start);
  assign me_c    = clamp_pm(pm_end);
  assign pm_up   = me_c >= ms_c;
  assign pm_mag  = pm_up ? me_c - ms_c : ms_c - me_c;
  assign nm1     = (n_periods > KW'(1)) ? n_periods - KW'(1) : KW'(1);
  assign klast_n = (n_periods == '0) ? '0 : n_periods - KW'(1);
  assign per_inc_n = AW'({{KW{1'b0}}, per_mag, {FW{1'b0}}} / {{AW{1'b0}}, nm1});
  assign pm_inc_n  = MW'({{KW{1'b0}}, pm_mag, {FW{1'b0}}} / {{MW{1'b0}}, nm1});

  // pulse state
  logic          trig_d;
  logic [CW-1:0] cnt, cur_per, cur_sh, per_base;
  logic [KW-1:0] k, klast;
  logic          per_dir, pm_dir;
  logic [AW-1:0] per_inc, per_acc, per_acc_nx;
  logic [6:0]    pm_base, cur_pm;
  logic [MW-1:0] pm_inc, pm_acc, pm_acc_nx;
  logic [DW-1:0] dead_q;
  logic [CW-1:0] per_nx;
  logic [6:0]    pm_nx;
  logic          go, last_cyc;

  assign go         = trig && !trig_d && !active && en;
  assign last_cyc   = cnt == cur_per - CW'(1);
  assign per_acc_nx = per_acc + per_inc;
  assign pm_acc_nx  = pm_acc + pm_inc;
  assign per_nx = per_dir ? per_base + per_acc_nx[AW-1:FW] : per_base - per_acc_nx[AW-1:FW];
  assign pm_nx  = pm_dir  ? pm_base + pm_acc_nx[MW-1:FW]   : pm_base - pm_acc_nx[MW-1:FW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_d <= 1'b0; active <= 1'b0; cnt <= '0; k <= '0; klast <= '0;
      cur_per <= PMIN; cur_sh <= '0; cur_pm <= 7'd100;
      per_base <= PMIN; per_dir <= 1'b1; per_inc <= '0; per_acc <= '0;
      pm_base <= 7'd100; pm_dir <= 1'b1; pm_inc <= '0; pm_acc <= '0;
      dead_q <= '0;
    end else begin
      trig_d <= trig;
      if (active && !en) begin
        active <= 1'b0;
      end else if (go) begin
        active   <= 1'b1;
        cnt      <= '0;
        k        <= '0;
        klast    <= klast_n;
        per_base <= ps_c;   per_dir <= per_up; per_inc <= per_inc_n; per_acc <= '0;
        pm_base  <= ms_c;   pm_dir  <= pm_up;  pm_inc  <= pm_inc_n;  pm_acc  <= '0;
        cur_per  <= ps_c;
        cur_pm   <= ms_c;
        cur_sh   <= shift_of(ps_c, ms_c);
        dead_q   <= dead;
      end else if (active) begin
        if (last_cyc) begin
          if (k == klast) begin
            active <= 1'b0;
          end else begin
            k       <= k + KW'(1);
            cnt     <= '0;
            per_acc <= per_acc_nx;
            pm_acc  <= pm_acc_nx;
            cur_per <= per_nx;
            cur_pm  <= pm_nx;
            cur_sh  <= shift_of(per_nx, pm_nx);
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  // gate pattern
  logic [CW-1:0] half, cnt2;
  logic [XW-1:0] half_d, wrap, dead_x;
  logic          a_hi, a_lo, b_hi, b_lo, run;

  assign half   = cur_per >> 1;
  assign dead_x = XW'(dead_q);
  assign half_d = {1'b0, half} + dead_x;
  assign wrap   = {1'b0, cnt} + {1'b0, cur_per} - {1'b0, cur_sh};
  assign cnt2   = (cnt >= cur_sh) ? cnt - cur_sh : wrap[CW-1:0];
  assign a_hi   = ({1'b0, cnt} >= dead_x) && (cnt < half);
  assign a_lo   = {1'b0, cnt} >= half_d;
  assign b_lo   = ({1'b0, cnt2} >= dead_x) && (cnt2 < half);
  assign b_hi   = {1'b0, cnt2} >= half_d;
  assign run    = active && en;

  for (genvar b = 0; b < NB; b++) begin : g_br
    assign gate[4*b +: 4] = run ? {b_lo, b_hi, a_lo, a_hi} : 4'b0;

    p_leg_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate[4*b] && gate[4*b+1]) && !(gate[4*b+2] && gate[4*b+3]));
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> gate == '0);
  p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(trig && !trig_d && en));
  p_per_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cur_per >= PMIN) && (cur_per <= PMAX));
  p_pm_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cur_pm >= PMF) && (cur_pm <= 7'd100));
  p_fault_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && en && !last_cyc) |=> active && (cnt == $past(cnt) + CW'(1)) && (k == $past(k)));
  p_period_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_cyc) |=> $stable(cur_per) && $stable(cur_sh));
endmodule

// File: tb/swept_bridge_gate_gen_test.sv
module swept_bridge_gate_gen_test;
  localparam int NB = 3, CW = 8, KW = 6, DW = 4, FW = 8;
  localparam int PMIN = 8, PMAX = 40, SPAN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, en = 1'b1;
  logic [CW-1:0] per_start = '0, per_end = '0;
  logic [6:0] pm_start = '0, pm_end = '0;
  logic [KW-1:0] n_periods = '0;
  logic [DW-1:0] dead = '0;
  logic [4*NB-1:0] gate;
  logic active;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  swept_bridge_gate_gen #(.NB(NB), .CW(CW), .KW(KW), .DW(DW), .FW(FW),
    .PER_MIN(PMIN), .PER_MAX(PMAX), .SPAN_MAX(SPAN), .PM_FLOOR(90)) uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .en(en), .per_start(per_start),
    .per_end(per_end), .pm_start(pm_start), .pm_end(pm_end), .n_periods(n_periods),
    .dead(dead), .gate(gate), .active(active));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  function automatic int exp_gate(input int c, input int per, input int sh, input int d);
    int h, c2, pat, g;
    h = per / 2;
    c2 = (c - sh + per) % per;
    pat = ((c >= d && c < h) ? 1 : 0) | ((c >= h + d) ? 2 : 0) |
          ((c2 >= h + d) ? 4 : 0) | ((c2 >= d && c2 < h) ? 8 : 0);
    g = 0;
    for (int b = 0; b < NB; b++) g |= pat << (4 * b);
    return g;
  endfunction

  task automatic run_pulse(input int ps, input int pe, input int ms, input int me,
                           input int n, input int d, input string tag, input bit poke);
    int psc, pec, msc, mec, nn, pinc, minc, per, pm, sh, pmag, mmag;
    psc = clampi(ps, PMIN, PMAX);
    pec = clampi(pe, PMIN, PMAX);
    if (pec > psc + SPAN) pec = psc + SPAN;
    if (pec < psc - SPAN) pec = psc - SPAN;
    msc = clampi(ms, 90, 100);
    mec = clampi(me, 90, 100);
    nn = (n == 0) ? 1 : n;
    pmag = pec >= psc ? pec - psc : psc - pec;
    mmag = mec >= msc ? mec - msc : msc - mec;
    pinc = nn > 1 ? (pmag << FW) / (nn - 1) : 0;
    minc = nn > 1 ? (mmag << FW) / (nn - 1) : 0;
    @(negedge clk);
    per_start = CW'(ps); per_end = CW'(pe); pm_start = 7'(ms); pm_end = 7'(me);
    n_periods = KW'(n); dead = DW'(d); trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k < nn; k++) begin
      per = pec >= psc ? psc + ((pinc * k) >> FW) : psc - ((pinc * k) >> FW);
      pm  = mec >= msc ? msc + ((minc * k) >> FW) : msc - ((minc * k) >> FW);
      sh  = per * (100 - pm) / 100;
      for (int c = 0; c < per; c++) begin
        chk(tag, {19'd0, active, gate}, (1 << 12) | exp_gate(c, per, sh, d));
        if (poke && k == 1 && c == 0) begin
          trig = 1'b1; per_start = 8'd40; per_end = 8'd9; pm_start = 7'd90;
          n_periods = 6'd1; dead = 4'd0;
        end
        if (poke && k == 1 && c == 1) trig = 1'b0;
        @(negedge clk);
      end
    end
    chk({tag, " end R2"}, {19'd0, active, gate}, 0);
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ns[4];
    ns = '{1, 2, 3, 6};
    repeat (3) @(negedge clk);
    chk("R1 reset", {19'd0, active, gate}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {19'd0, active, gate}, 0);

    run_pulse(20, 24, 93, 100, 5, 1, "R3/R5/R7/R8/R11 rising", 0);
    run_pulse(30, 26, 100, 95, 4, 2, "R3/R5/R7 falling", 0);
    run_pulse(20, 35, 95, 100, 4, 1, "R4 span clamp", 0);
    run_pulse(3, 60, 90, 90, 3, 0, "R4 range clamp", 0);
    run_pulse(20, 20, 50, 120, 3, 1, "R6 phase clamp", 0);
    run_pulse(16, 20, 92, 100, 0, 1, "R2 zero periods", 0);
    run_pulse(16, 20, 94, 100, 4, 1, "R10 retrigger ignored", 1);

    for (int ps = PMIN; ps <= PMAX; ps += 4)
      for (int i = 0; i < 4; i++)
        run_pulse(ps, ps + (i - 1) * 2, 90 + 2 * i, 100, ns[i], i % 3, "R3/R5/R7 sweep", 0);

    // fault shutdown
    @(negedge clk);
    per_start = 8'd16; per_end = 8'd16; pm_start = 7'd100; pm_end = 7'd100;
    n_periods = 6'd4; dead = 4'd1; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int c = 0; c < 10; c++) begin
      chk("R9 before fault", {19'd0, active, gate}, (1 << 12) | exp_gate(c, 16, 0, 1));
      @(negedge clk);
    end
    en = 1'b0;
    #1;
    chk("R9 same-cycle blank", {20'd0, gate}, 0);
    @(negedge clk);
    chk("R9 pulse ended", {31'd0, active}, 0);
    en = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R9 held low", {19'd0, active, gate}, 0);
    end
    en = 1'b0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 trigger while disabled", {19'd0, active, gate}, 0);
    end
    en = 1'b1;
    run_pulse(12, 14, 91, 100, 2, 1, "R9 restart after fault", 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule